// File: doc/BRIEF.md
# Oversampling Serial Receiver with Noise Flagging

This block receives an asynchronous serial line that is sampled on a strobe running at sixteen times the baud rate. It watches the idle-high line for a qualified falling edge and confirms the start bit with three early samples. It then resolves every bit of the frame by majority vote over three mid-bit samples. The data bits are collected least significant bit first into a shift register, and a single stop bit closes the frame. Each completed character goes into one receive buffer, unless an earlier character there is still unread or an earlier framing error is still pending.

Four status flags are reported: data ready, overrun, noise and framing error. Data ready is cleared by a two-step handshake: a status read while the flag is set, then a data read. The other three flags are cleared by a dedicated clear strobe. Every falling edge seen during a frame realigns the sub-sample phase, which lets the receiver follow a sender whose baud rate is off. After a framing error that is not a break, the edge history is refilled with ones, so a start bit that follows at once is still found.

Top module: `osr_serial_rx`

## Requirements
- R1: After reset, data_ready, overrun, noise_err and frame_err are 0 and rx_data is all zeros.
- R2: The line is sampled only in cycles where os_tick is 1, and rxd is ignored in all other cycles. A falling edge is a 0 sample that follows three consecutive 1 samples, so a low period preceded by fewer than three 1 samples starts no frame.
- R3: The sample slots of a bit are numbered 1 to 16, and slot 1 is the tick where the edge is seen. The start bit is accepted when at least two of the samples at slots 3, 5 and 7 are 0, whatever slots 8 to 10 show. Otherwise the frame is dropped and no character results.
- R4: Each data bit and the stop bit take the majority of the samples at slots 8, 9 and 10. Data arrives least significant bit first. wide_mode=1 selects 9 data bits, wide_mode=0 selects 8, and rx_data[8] then reads 0.
- R5: noise_err is set when a character enters the buffer if any sample of that frame disagrees with its bit's decided value. The samples that count are start slots 3, 5, 7, 8, 9 and 10, and slots 8, 9 and 10 of every other bit. Samples at other slots have no effect.
- R6: When the stop bit is decided as 1, data_ready is 0 and frame_err is 0, the character is written to rx_data and data_ready goes to 1.
- R7: When a frame completes with a stop bit of 1 while data_ready is 1, overrun is set, the new character is discarded and rx_data keeps its value.
- R8: data_ready clears when status_rd is seen while data_ready is 1 and data_rd is seen later. A data_rd without that earlier status_rd does not clear it, and neither does flag_clr.
- R9: flag_clr clears overrun, noise_err and frame_err. If a flag is set in the same cycle as the clear, the set wins.
- R10: Every qualified falling edge seen inside a frame resets the sub-sample phase to slot 1. A frame whose bits are 14 ticks long is therefore still received without noise when it has a falling edge every two bits.
- R11: A stop bit decided as 0 sets frame_err and does not store the character. While frame_err is 1, no completed character is stored and data_ready does not change.
- R12: On a framing error whose data bits are not all zero, the edge history is filled with ones, so a start bit that follows the low stop bit directly is detected. On a break frame (all data bits and the stop bit 0) the history is not filled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversample strobe at sixteen times the baud rate |
| rxd | input | 1 | Serial line, idle high |
| wide_mode | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| status_rd | input | 1 | Status read strobe, first step of the data-ready clear |
| data_rd | input | 1 | Data read strobe, second step of the data-ready clear |
| flag_clr | input | 1 | Clears overrun, noise and framing error |
| rx_data | output | 9 | Receive buffer contents |
| data_ready | output | 1 | Buffer holds an unread character |
| overrun | output | 1 | A character was lost because the buffer was full |
| noise_err | output | 1 | A sample of the stored frame disagreed with its bit value |
| frame_err | output | 1 | A frame ended with a low stop bit |

## Verification
A sub-sample phase that is off by a few slots does not show at once. It shows only at the next transfer, as a wrong bit in rx_data or as a spurious noise_err, about one frame time (roughly 160 ticks) after the fault. A wrong edge history shows as a missing character or as an extra one that does not exist on the line. The most sensitive case is back-to-back frames after a low stop bit, where it surfaces one frame later. Errors in the flag and buffer state are visible in the cycle after the stop-bit vote or after the clearing strobe, so the bench checks those right after each event.

// File: rtl/rxo_pkg.sv
package rxo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;

    // sample positions, zero based (slot index = slot number - 1)
    localparam int CONF_A = 2;
    localparam int CONF_B = 4;
    localparam int CONF_C = 6;
    localparam int VOTE_A = 7;
    localparam int VOTE_B = 8;
    localparam int VOTE_C = 9;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/rxo_edge.sv
module rxo_edge #(
    parameter int HIST_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic rxd_i,
    input  logic preload_i,
    output logic edge_o
);

    typedef struct packed {
        logic [HIST_LEN-1:0] hist;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        edge_o = tick_i && (&st_q.hist) && !rxd_i;
        if (tick_i) begin
            st_d.hist = {st_q.hist[HIST_LEN-2:0], rxd_i};
            if (preload_i) begin
                st_d.hist = '1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rxo_slot.sv
module rxo_slot #(
    parameter int SLOTS = 16,
    localparam int SW = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          realign_i,
    output logic [SW-1:0] slot_o
);

    typedef struct packed {
        logic [SW-1:0] slot;
    } slot_state_t;

    slot_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (realign_i || st_q.slot == SW'(SLOTS - 1)) begin
            slot_o = '0;
        end else begin
            slot_o = st_q.slot + SW'(1);
        end
        if (tick_i) begin
            st_d.slot = slot_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.slot <= SW'(SLOTS - 1);
        end else begin
            st_q <= st_d;
        end
    end

    // R10
    realign_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && realign_i) |=> (st_q.slot == '0));

endmodule

// File: rtl/rxo_ctrl.sv
module rxo_ctrl
    import rxo_pkg::*;
#(
    parameter int LONG_W = 9,
    parameter int SLOTS  = 16,
    localparam int SW = $clog2(SLOTS),
    localparam int BW = $clog2(LONG_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rxd_i,
    input  logic              edge_i,
    input  logic [SW-1:0]     slot_i,
    input  logic              wide_i,
    output logic              done_o,
    output logic [LONG_W-1:0] fr_data_o,
    output logic              fr_noise_o,
    output logic              fr_stop_o,
    output logic              preload_o
);

    typedef struct packed {
        rx_state_e         state;
        logic [BW-1:0]     bitcnt;
        logic [LONG_W-1:0] data;
        logic              noise;
        logic [1:0]        zeros;
        logic              va;
        logic              vb;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    logic          vote;
    logic          disagree;
    logic [1:0]    zsum;
    logic [BW-1:0] last_bit;
    logic          brk;
    int            slot_n;

    always_comb begin
        st_d       = st_q;
        done_o     = 1'b0;
        preload_o  = 1'b0;
        slot_n     = int'(slot_i);
        vote       = maj3(st_q.va, st_q.vb, rxd_i);
        disagree   = (st_q.va != vote) || (st_q.vb != vote) || (rxd_i != vote);
        zsum       = st_q.zeros + {1'b0, ~rxd_i};
        last_bit   = wide_i ? BW'(LONG_W - 1) : BW'(LONG_W - 2);
        fr_data_o  = st_q.data;
        fr_noise_o = st_q.noise | disagree;
        fr_stop_o  = vote;
        brk        = (st_q.data == '0) && !vote;

        if (tick_i) begin
            unique case (st_q.state)
                ST_IDLE, ST_START: begin
                    if (edge_i) begin
                        st_d.state  = ST_START;
                        st_d.zeros  = '0;
                        st_d.noise  = 1'b0;
                        st_d.data   = '0;
                        st_d.bitcnt = '0;
                    end else if (st_q.state == ST_START) begin
                        if (slot_n == CONF_A || slot_n == CONF_B) begin
                            if (!rxd_i) st_d.zeros = st_q.zeros + 2'd1;
                            else        st_d.noise = 1'b1;
                        end else if (slot_n == CONF_C) begin
                            if (zsum < 2'd2) begin
                                st_d.state = ST_IDLE;
                            end else if (rxd_i) begin
                                st_d.noise = 1'b1;
                            end
                        end else if (slot_n == VOTE_A || slot_n == VOTE_B) begin
                            if (rxd_i) st_d.noise = 1'b1;
                        end else if (slot_n == VOTE_C) begin
                            if (rxd_i) st_d.noise = 1'b1;
                            st_d.state  = ST_DATA;
                            st_d.bitcnt = '0;
                        end
                    end
                end
                ST_DATA: begin
                    if (slot_n == VOTE_A) begin
                        st_d.va = rxd_i;
                    end else if (slot_n == VOTE_B) begin
                        st_d.vb = rxd_i;
                    end else if (slot_n == VOTE_C) begin
                        st_d.data[st_q.bitcnt] = vote;
                        st_d.noise = st_q.noise | disagree;
                        if (st_q.bitcnt == last_bit) begin
                            st_d.state = ST_STOP;
                        end else begin
                            st_d.bitcnt = st_q.bitcnt + BW'(1);
                        end
                    end
                end
                ST_STOP: begin
                    if (slot_n == VOTE_A) begin
                        st_d.va = rxd_i;
                    end else if (slot_n == VOTE_B) begin
                        st_d.vb = rxd_i;
                    end else if (slot_n == VOTE_C) begin
                        done_o     = 1'b1;
                        preload_o  = !vote && !brk;
                        st_d.state = ST_IDLE;
                    end
                end
                default: st_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{state: ST_IDLE, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    // R4
    bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.state == ST_DATA) |-> (st_q.bitcnt <= BW'(LONG_W - 1)));

    // R5
    fresh_frame_noise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q.state) == ST_IDLE && st_q.state == ST_START) |-> !st_q.noise);

endmodule

// File: rtl/rxo_flags.sv
module rxo_flags #(
    parameter int LONG_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [LONG_W-1:0] fr_data_i,
    input  logic              fr_noise_i,
    input  logic              fr_stop_i,
    input  logic              status_rd_i,
    input  logic              data_rd_i,
    input  logic              flag_clr_i,
    output logic [LONG_W-1:0] data_o,
    output logic              ready_o,
    output logic              ovr_o,
    output logic              noise_o,
    output logic              ferr_o
);

    typedef struct packed {
        logic [LONG_W-1:0] data;
        logic              rdy;
        logic              ovr;
        logic              noise;
        logic              ferr;
        logic              armed;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (status_rd_i && st_q.rdy) begin
            st_d.armed = 1'b1;
        end
        if (data_rd_i && st_q.armed) begin
            st_d.rdy   = 1'b0;
            st_d.armed = 1'b0;
        end
        if (flag_clr_i) begin
            st_d.ovr   = 1'b0;
            st_d.noise = 1'b0;
            st_d.ferr  = 1'b0;
        end
        if (done_i && !st_q.ferr) begin
            if (!fr_stop_i) begin
                st_d.ferr = 1'b1;
            end else if (st_q.rdy) begin
                st_d.ovr = 1'b1;
            end else begin
                st_d.data = fr_data_i;
                st_d.rdy  = 1'b1;
                if (fr_noise_i) st_d.noise = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_o  = st_q.data;
    assign ready_o = st_q.rdy;
    assign ovr_o   = st_q.ovr;
    assign noise_o = st_q.noise;
    assign ferr_o  = st_q.ferr;

    // R7
    overrun_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ovr) |-> $past(st_q.rdy));

    // R7
    held_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rdy && $past(st_q.rdy)) |-> $stable(st_q.data));

    // R11
    no_store_on_ferr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.rdy) |-> !$past(st_q.ferr));

    // R5
    noise_with_transfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.noise) |-> $rose(st_q.rdy));

endmodule

// File: rtl/osr_serial_rx.sv
module osr_serial_rx #(
    parameter int LONG_W   = 9,
    parameter int SLOTS    = 16,
    parameter int HIST_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic              wide_mode,
    input  logic              status_rd,
    input  logic              data_rd,
    input  logic              flag_clr,
    output logic [LONG_W-1:0] rx_data,
    output logic              data_ready,
    output logic              overrun,
    output logic              noise_err,
    output logic              frame_err
);

    localparam int SW = $clog2(SLOTS);

    logic              edge_w;
    logic              preload_w;
    logic [SW-1:0]     slot_w;
    logic              done_w;
    logic [LONG_W-1:0] fr_data_w;
    logic              fr_noise_w;
    logic              fr_stop_w;

    rxo_edge #(.HIST_LEN(HIST_LEN)) i_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (os_tick),
        .rxd_i     (rxd),
        .preload_i (preload_w),
        .edge_o    (edge_w)
    );

    rxo_slot #(.SLOTS(SLOTS)) i_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (os_tick),
        .realign_i (edge_w),
        .slot_o    (slot_w)
    );

    rxo_ctrl #(.LONG_W(LONG_W), .SLOTS(SLOTS)) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (os_tick),
        .rxd_i      (rxd),
        .edge_i     (edge_w),
        .slot_i     (slot_w),
        .wide_i     (wide_mode),
        .done_o     (done_w),
        .fr_data_o  (fr_data_w),
        .fr_noise_o (fr_noise_w),
        .fr_stop_o  (fr_stop_w),
        .preload_o  (preload_w)
    );

    rxo_flags #(.LONG_W(LONG_W)) i_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .done_i      (done_w),
        .fr_data_i   (fr_data_w),
        .fr_noise_i  (fr_noise_w),
        .fr_stop_i   (fr_stop_w),
        .status_rd_i (status_rd),
        .data_rd_i   (data_rd),
        .flag_clr_i  (flag_clr),
        .data_o      (rx_data),
        .ready_o     (data_ready),
        .ovr_o       (overrun),
        .noise_o     (noise_err),
        .ferr_o      (frame_err)
    );

endmodule

// File: tb/test_osr_serial_rx.sv
module test_osr_serial_rx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b0;
    logic       wide_mode = 1'b0;
    logic       status_rd = 1'b0;
    logic       data_rd = 1'b0;
    logic       flag_clr = 1'b0;
    logic [8:0] rx_data;
    logic       data_ready, overrun, noise_err, frame_err;

    int n_chk = 0;
    int n_fail = 0;
    int gap = 1;
    bit inv_between = 1'b0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    osr_serial_rx i_osr_serial_rx (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .wide_mode(wide_mode), .status_rd(status_rd), .data_rd(data_rd),
        .flag_clr(flag_clr), .rx_data(rx_data), .data_ready(data_ready),
        .overrun(overrun), .noise_err(noise_err), .frame_err(frame_err)
    );

    typedef struct packed {
        logic       wide;
        logic [8:0] data;
        logic [3:0] gbit;    // 0 start, k data bit k-1, 15 none
        logic [4:0] gslot;   // slot number 1..16
        logic       exp_noise;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{1'b0, 9'h0A5, 4'd15, 5'd0,  1'b0},   // R4 R6
        '{1'b0, 9'h000, 4'd15, 5'd0,  1'b0},
        '{1'b0, 9'h0FF, 4'd15, 5'd0,  1'b0},
        '{1'b1, 9'h1A5, 4'd15, 5'd0,  1'b0},   // R4 wide
        '{1'b0, 9'h03C, 4'd1,  5'd9,  1'b1},   // R5 vote slot
        '{1'b0, 9'h03C, 4'd2,  5'd4,  1'b0},   // R5 unsampled slot
        '{1'b0, 9'h081, 4'd0,  5'd3,  1'b1},   // R3 one confirm sample high
        '{1'b1, 9'h0F0, 4'd9,  5'd10, 1'b1},   // R5 ninth bit
        '{1'b0, 9'h081, 4'd0,  5'd8,  1'b1}    // R3 start slot 8 ignored for accept
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic v);
        @(negedge clk);
        rxd = v;
        os_tick = 1'b1;
        @(negedge clk);
        os_tick = 1'b0;
        rxd = inv_between ? ~v : v;
        for (int i = 1; i < gap; i++) @(negedge clk);
    endtask

    task automatic send_frame(input logic [8:0] d, input int nb, input logic stop_v,
                              input int gbit, input int gslot, input int blen,
                              input int pre, input int post);
        for (int i = 0; i < pre; i++) step(1'b1);
        for (int e = 0; e <= nb + 1; e++) begin
            logic val;
            if (e == 0)       val = 1'b0;
            else if (e <= nb) val = d[e-1];
            else              val = stop_v;
            for (int t = 1; t <= blen; t++) begin
                step((e == gbit && t == gslot) ? ~val : val);
            end
        end
        for (int i = 0; i < post; i++) step(1'b1);
    endtask

    task automatic pulse_status;
        @(negedge clk); status_rd = 1'b1;
        @(negedge clk); status_rd = 1'b0;
    endtask

    task automatic pulse_data;
        @(negedge clk); data_rd = 1'b1;
        @(negedge clk); data_rd = 1'b0;
    endtask

    task automatic pulse_clr;
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic clear_all;
        pulse_status();
        pulse_data();
        pulse_clr();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 data_ready", data_ready, 0);
        check("R1 overrun", overrun, 0);
        check("R1 noise_err", noise_err, 0);
        check("R1 frame_err", frame_err, 0);
        check("R1 rx_data", rx_data, 0);

        // R2: only two high samples before the low start: no frame
        for (int i = 0; i < 20; i++) step(1'b0);
        step(1'b1);
        step(1'b1);
        send_frame(9'h0FF, 8, 1'b1, -1, 0, 16, 0, 20);
        check("R2 no edge after two ones", data_ready, 0);

        // table of frames
        foreach (VECS[k]) begin
            int nb;
            int gb;
            wide_mode = VECS[k].wide;
            nb = VECS[k].wide ? 9 : 8;
            gb = (VECS[k].gbit == 4'd15) ? -1 : int'(VECS[k].gbit);
            send_frame(VECS[k].data, nb, 1'b1, gb, int'(VECS[k].gslot), 16, 4, 4);
            check("R6 ready after frame", data_ready, 1);
            check("R4 rx_data", rx_data, VECS[k].data);
            check("R5 noise_err", noise_err, VECS[k].exp_noise);
            clear_all();
        end
        wide_mode = 1'b0;

        // R8 read handshake
        send_frame(9'h05C, 8, 1'b1, -1, 0, 16, 4, 4);
        pulse_data();
        check("R8 data_rd alone keeps ready", data_ready, 1);
        pulse_clr();
        check("R8 flag_clr keeps ready", data_ready, 1);
        pulse_status();
        pulse_data();
        check("R8 status then data clears ready", data_ready, 0);

        // R7 overrun, R9 clear
        send_frame(9'h012, 8, 1'b1, -1, 0, 16, 4, 4);
        send_frame(9'h034, 8, 1'b1, -1, 0, 16, 4, 4);
        check("R7 overrun set", overrun, 1);
        check("R7 first char kept", rx_data, 9'h012);
        pulse_clr();
        check("R9 overrun cleared", overrun, 0);
        clear_all();

        // R3 false start: low for two ticks only
        for (int i = 0; i < 4; i++) step(1'b1);
        step(1'b0);
        step(1'b0);
        for (int i = 0; i < 200; i++) step(1'b1);
        check("R3 false start dropped", data_ready, 0);

        // R2 ticks gated, line inverted between ticks
        gap = 3;
        inv_between = 1'b1;
        send_frame(9'h0C3, 8, 1'b1, -1, 0, 16, 4, 4);
        gap = 1;
        inv_between = 1'b0;
        check("R2 gated data", rx_data, 9'h0C3);
        check("R2 gated no noise", noise_err, 0);
        clear_all();

        // R10 resync with 14-tick bits
        send_frame(9'h055, 8, 1'b1, -1, 0, 14, 4, 8);
        check("R10 ready", data_ready, 1);
        check("R10 data", rx_data, 9'h055);
        check("R10 no noise", noise_err, 0);
        clear_all();

        // R11 framing error blocks later frames
        send_frame(9'h011, 8, 1'b0, -1, 0, 16, 4, 200);
        check("R11 frame_err set", frame_err, 1);
        check("R11 not stored", data_ready, 0);
        send_frame(9'h066, 8, 1'b1, -1, 0, 16, 4, 4);
        check("R11 blocked while set", data_ready, 0);
        pulse_clr();
        check("R9 frame_err cleared", frame_err, 0);
        send_frame(9'h099, 8, 1'b1, -1, 0, 16, 4, 4);
        check("R11 resumes after clear", rx_data, 9'h099);
        clear_all();

        // R12 preload: start follows the low stop bit directly
        fork
            begin
                send_frame(9'h03C, 8, 1'b0, -1, 0, 16, 4, 0);
                send_frame(9'h007, 8, 1'b1, -1, 0, 16, 0, 20);
            end
            begin
                repeat (400) @(negedge clk);
                check("R11 frame_err before clear", frame_err, 1);
                @(negedge clk); flag_clr = 1'b1;
                @(negedge clk); flag_clr = 1'b0;
            end
        join
        check("R12 back-to-back ready", data_ready, 1);
        check("R12 back-to-back data", rx_data, 9'h007);
        clear_all();

        // R12 break: no preload
        send_frame(9'h000, 8, 1'b0, -1, 0, 16, 4, 0);
        for (int i = 0; i < 16; i++) step(1'b0);
        check("R11 break sets frame_err", frame_err, 1);
        for (int i = 0; i < 10; i++) step(1'b1);
        pulse_clr();
        send_frame(9'h05A, 8, 1'b1, -1, 0, 16, 4, 4);
        check("R12 after break ready", data_ready, 1);
        check("R12 after break data", rx_data, 9'h05A);
        check("R12 after break no frame_err", frame_err, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule